// File: doc/BRIEF.md
# Vector Gather/Scatter Memory Lane Sequencer

This unit turns one vector or scalar memory command into a series of single-word memory transactions. A vector command carries a per-lane address, per-lane store data, the current destination contents and a lane mask. For a gather it reads one 32-bit word for each enabled lane; for a scatter it writes one 32-bit word for each enabled lane. Enabled lanes are visited from the lowest lane upward, and only one transaction is in flight at any time. When the last enabled lane has been answered, the unit presents the whole updated vector on its result port for one cycle.

Scalar commands use lane 0 only and ignore the mask. A scalar load or store may be 8, 16 or 32 bits wide. Loads take the addressed byte or halfword out of the returned word in little-endian order and then widen it to 32 bits, with either sign or zero fill. Stores shift the data to its byte position and raise the matching byte enables. Every memory transaction is tagged with the address-space identifier of the thread that issued the command. That identifier is looked up in a per-thread identifier table that the block receives as an input.

Top module: `vlsu_lane_seq`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `mem_req_valid` and `res_valid` are 0.
- R2: A gather (`cmd_op`=2'b10) issues one read (`mem_req_we`=0) for each lane whose mask bit is 1. The address comes from that lane's slot of `cmd_addr`, bits [32*i+31:32*i], and lanes are issued in ascending order. Each response word becomes that lane's result.
- R3: Lanes whose mask bit is 0 produce no memory transaction. On a gather, their result equals the matching slot of `cmd_old`.
- R4: A scatter (`cmd_op`=2'b11) issues one write (`mem_req_we`=1) for each enabled lane, in ascending lane order. Each write uses that lane's address and its `cmd_wdata` slot, and the result equals `cmd_old`.
- R5: Gather and scatter ignore `cmd_size`. Every request they make has `mem_req_be`=4'b1111.
- R6: No request is presented while an earlier request still waits for its response.
- R7: A vector command with an all-zero mask makes no request, and `res_valid` is 1 in the cycle right after the command is accepted.
- R8: A scalar load (`cmd_op`=2'b00) makes exactly one read at lane 0's address and ignores the mask. `cmd_size` 2'b00 selects the byte at `addr[1:0]`, 2'b01 the halfword at `addr[1]`, and 2'b10 the whole word, in little-endian order. The value is sign-extended when `cmd_signed`=1 and zero-extended otherwise, and is placed in result lane 0; lanes 1 and up equal `cmd_old`.
- R9: A scalar store (`cmd_op`=2'b01) makes exactly one write. Byte size writes data[7:0] shifted left by 8*addr[1:0] with enable 4'b0001<<addr[1:0]. Halfword size writes data[15:0] shifted by 16*addr[1] with enable 4'b0011<<(2*addr[1]). Word size writes the word with enable 4'b1111.
- R10: Every request carries `mem_req_asid` equal to the slot of `asid_table` (bits [10*t+9:10*t]) selected by the command's `cmd_thread` t.
- R11: `cmd_ready` is 0 from acceptance until the result has been delivered. `res_valid` is a one-cycle pulse, and `res_thread` echoes `cmd_thread`.
- R12: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays asserted with the same address, data and byte enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| asid_table | input | THREADS*10 | Address-space identifier of each thread |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command taken when valid |
| cmd_op | input | 2 | 00 scalar load, 01 scalar store, 10 gather, 11 scatter |
| cmd_size | input | 2 | 00 byte, 01 halfword, 10 word (scalar only) |
| cmd_signed | input | 1 | Sign-extend scalar load |
| cmd_thread | input | TID_W | Issuing thread |
| cmd_mask | input | LANES | Lane enable mask (vector only) |
| cmd_addr | input | LANES*32 | Per-lane addresses, lane 0 used by scalar ops |
| cmd_wdata | input | LANES*32 | Per-lane store data |
| cmd_old | input | LANES*32 | Previous destination vector |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | Write request |
| mem_req_addr | output | 32 | Request address |
| mem_req_wdata | output | 32 | Write data |
| mem_req_be | output | 4 | Byte enables |
| mem_req_asid | output | 10 | Address-space tag |
| mem_rsp_valid | input | 1 | Response for the outstanding request |
| mem_rsp_data | input | 32 | Read data |
| res_valid | output | 1 | Result pulse |
| res_data | output | LANES*32 | Updated vector |
| res_thread | output | TID_W | Thread of the result |

## Verification
The bench builds the unit with its defaults: eight lanes and four threads. Eight lanes allow sparse masks with gaps at both ends and in the middle, so the checks cover ascending issue order and the keeping of old values in skipped lanes. Four threads, each with a different identifier, make a wrong tag selection visible. The memory model varies its response latency and drops its ready signal on a fixed rhythm, which exercises request holding and the single-outstanding rule.

// File: rtl/vlsu_pkg.sv
package vlsu_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTES_W = WORD_W / 8;
    localparam int ASID_W  = 10;

    typedef enum logic [1:0] {
        OP_LOAD    = 2'b00,
        OP_STORE   = 2'b01,
        OP_GATHER  = 2'b10,
        OP_SCATTER = 2'b11
    } vop_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WYDE  = 2'b01,
        SZ_TETRA = 2'b10,
        SZ_RSVD  = 2'b11
    } vsz_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } vseq_e;

    typedef struct packed {
        logic [WORD_W-1:0]  data;
        logic [BYTES_W-1:0] be;
    } wr_beat_t;

    function automatic logic op_is_vec(vop_e op);
        return op[1];
    endfunction

    function automatic logic op_is_wr(vop_e op);
        return op[0];
    endfunction

endpackage

// File: rtl/vlsu_lane_pick.sv
module vlsu_lane_pick #(
    parameter int LANES  = 8,
    parameter int LIDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0]  pend,
    output logic [LIDX_W-1:0] idx,
    output logic              any
);
    logic [LANES-1:0] first;

    for (genvar i = 0; i < LANES; i++) begin : g_first
        if (i == 0) begin : g_lo
            assign first[i] = pend[0];
        end else begin : g_hi
            assign first[i] = pend[i] & ~(|pend[i-1:0]);
        end
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < LANES; i++) begin
            if (first[i]) idx = idx | LIDX_W'(i);
        end
    end

    assign any = |pend;
endmodule

// File: rtl/vlsu_load_fmt.sv
module vlsu_load_fmt
    import vlsu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  vsz_e              size,
    input  logic [1:0]        off,
    input  logic              sgn,
    output logic [WORD_W-1:0] val
);
    logic [7:0]  b_sel;
    logic [15:0] w_sel;

    always_comb begin
        b_sel = 8'(word >> (8 * off));
        w_sel = 16'(word >> (16 * off[1]));
        unique case (size)
            SZ_BYTE: val = {{(WORD_W-8){sgn & b_sel[7]}}, b_sel};
            SZ_WYDE: val = {{(WORD_W-16){sgn & w_sel[15]}}, w_sel};
            default: val = word;
        endcase
    end
endmodule

// File: rtl/vlsu_store_fmt.sv
module vlsu_store_fmt
    import vlsu_pkg::*;
(
    input  logic [WORD_W-1:0] data,
    input  vsz_e              size,
    input  logic [1:0]        off,
    output wr_beat_t          beat
);
    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                beat.data = {{(WORD_W-8){1'b0}}, data[7:0]} << (8 * off);
                beat.be   = BYTES_W'(4'b0001 << off);
            end
            SZ_WYDE: begin
                beat.data = {{(WORD_W-16){1'b0}}, data[15:0]} << (16 * off[1]);
                beat.be   = BYTES_W'(4'b0011 << (2 * off[1]));
            end
            default: begin
                beat.data = data;
                beat.be   = '1;
            end
        endcase
    end
endmodule

// File: rtl/vlsu_lane_seq.sv
module vlsu_lane_seq
    import vlsu_pkg::*;
#(
    parameter int LANES   = 8,
    parameter int THREADS = 4,
    localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
    localparam int VEC_W  = LANES * WORD_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [THREADS*ASID_W-1:0]  asid_table,
    input  logic                       cmd_valid,
    output logic                       cmd_ready,
    input  logic [1:0]                 cmd_op,
    input  logic [1:0]                 cmd_size,
    input  logic                       cmd_signed,
    input  logic [TID_W-1:0]           cmd_thread,
    input  logic [LANES-1:0]           cmd_mask,
    input  logic [VEC_W-1:0]           cmd_addr,
    input  logic [VEC_W-1:0]           cmd_wdata,
    input  logic [VEC_W-1:0]           cmd_old,
    output logic                       mem_req_valid,
    input  logic                       mem_req_ready,
    output logic                       mem_req_we,
    output logic [WORD_W-1:0]          mem_req_addr,
    output logic [WORD_W-1:0]          mem_req_wdata,
    output logic [BYTES_W-1:0]         mem_req_be,
    output logic [ASID_W-1:0]          mem_req_asid,
    input  logic                       mem_rsp_valid,
    input  logic [WORD_W-1:0]          mem_rsp_data,
    output logic                       res_valid,
    output logic [VEC_W-1:0]           res_data,
    output logic [TID_W-1:0]           res_thread
);
    vseq_e               st_q;
    vop_e                op_q;
    vsz_e                size_q;
    logic                sgn_q;
    logic [TID_W-1:0]    tid_q;
    logic [ASID_W-1:0]   asid_q;
    logic [LANES-1:0]    pend_q;
    logic [VEC_W-1:0]    addr_q;
    logic [VEC_W-1:0]    wdat_q;
    logic [VEC_W-1:0]    res_q;

    logic [LIDX_W-1:0]   cur_lane;
    logic                pend_any;
    logic [LANES-1:0]    pend_next;
    logic [LANES-1:0]    start_pend;
    logic [WORD_W-1:0]   lane_addr;
    logic [WORD_W-1:0]   lane_wdat;
    logic [WORD_W-1:0]   ld_val;
    wr_beat_t            st_beat;
    vop_e                cmd_op_e;
    logic                accept;
    logic                req_fire;

    assign cmd_op_e = vop_e'(cmd_op);
    assign accept   = cmd_valid && cmd_ready;
    assign req_fire = mem_req_valid && mem_req_ready;

    vlsu_lane_pick #(.LANES(LANES), .LIDX_W(LIDX_W)) u_pick (
        .pend (pend_q),
        .idx  (cur_lane),
        .any  (pend_any)
    );

    assign lane_addr = addr_q[cur_lane*WORD_W +: WORD_W];
    assign lane_wdat = wdat_q[cur_lane*WORD_W +: WORD_W];

    vlsu_load_fmt u_ldf (
        .word (mem_rsp_data),
        .size (size_q),
        .off  (lane_addr[1:0]),
        .sgn  (sgn_q),
        .val  (ld_val)
    );

    vlsu_store_fmt u_stf (
        .data (lane_wdat),
        .size (size_q),
        .off  (lane_addr[1:0]),
        .beat (st_beat)
    );

    always_comb begin
        pend_next = pend_q;
        pend_next[cur_lane] = 1'b0;
        start_pend = op_is_vec(cmd_op_e) ? cmd_mask : LANES'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            op_q   <= OP_LOAD;
            size_q <= SZ_TETRA;
            sgn_q  <= 1'b0;
            tid_q  <= '0;
            asid_q <= '0;
            pend_q <= '0;
            addr_q <= '0;
            wdat_q <= '0;
            res_q  <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        op_q   <= cmd_op_e;
                        size_q <= vsz_e'(cmd_size);
                        sgn_q  <= cmd_signed;
                        tid_q  <= cmd_thread;
                        asid_q <= asid_table[cmd_thread*ASID_W +: ASID_W];
                        pend_q <= start_pend;
                        addr_q <= cmd_addr;
                        wdat_q <= cmd_wdata;
                        res_q  <= cmd_old;
                        st_q   <= (start_pend == '0) ? ST_DONE : ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (mem_req_ready) st_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!op_is_wr(op_q)) begin
                            res_q[cur_lane*WORD_W +: WORD_W] <=
                                op_is_vec(op_q) ? mem_rsp_data : ld_val;
                        end
                        pend_q <= pend_next;
                        st_q   <= (pend_next == '0) ? ST_DONE : ST_ISSUE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign cmd_ready     = (st_q == ST_IDLE);
    assign mem_req_valid = (st_q == ST_ISSUE) && pend_any;
    assign mem_req_we    = op_is_wr(op_q);
    assign mem_req_addr  = lane_addr;
    assign mem_req_wdata = op_is_vec(op_q) ? lane_wdat : st_beat.data;
    assign mem_req_be    = op_is_vec(op_q) ? '1 : st_beat.be;
    assign mem_req_asid  = asid_q;
    assign res_valid     = (st_q == ST_DONE);
    assign res_data      = res_q;
    assign res_thread    = tid_q;

    // Observation state for the properties below.
    logic              outst_q;
    logic              seen_q;
    logic [LIDX_W-1:0] last_q;
    logic [LANES-1:0]  mask_chk_q;
    logic              vec_chk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            outst_q    <= 1'b0;
            seen_q     <= 1'b0;
            last_q     <= '0;
            mask_chk_q <= '0;
            vec_chk_q  <= 1'b0;
        end else begin
            if (req_fire) outst_q <= 1'b1;
            else if (mem_rsp_valid) outst_q <= 1'b0;
            if (accept) begin
                seen_q     <= 1'b0;
                mask_chk_q <= cmd_mask;
                vec_chk_q  <= cmd_op[1];
            end else if (req_fire) begin
                seen_q <= 1'b1;
                last_q <= cur_lane;
            end
        end
    end

    assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (rst)
        outst_q |-> !mem_req_valid);

    assert_ascending_lanes_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && vec_chk_q && seen_q) |-> (cur_lane > last_q));

    assert_masked_silent_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && vec_chk_q) |-> mask_chk_q[cur_lane]);

    assert_vector_tetra_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && vec_chk_q) |-> (mem_req_be == '1));

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata)
             && $stable(mem_req_be)));

    assert_res_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> (!res_valid && cmd_ready));

    assert_empty_fast_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && cmd_op[1] && (cmd_mask == '0)) |=> res_valid);

endmodule

// File: tb/sim_vlsu_lane_seq.sv
module sim_vlsu_lane_seq;
    localparam int LANES = 8;
    localparam int THREADS = 4;
    localparam int VW = LANES * 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [THREADS*10-1:0] asid_table;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [1:0] cmd_op = '0;
    logic [1:0] cmd_size = '0;
    logic cmd_signed = 1'b0;
    logic [1:0] cmd_thread = '0;
    logic [LANES-1:0] cmd_mask = '0;
    logic [VW-1:0] cmd_addr = '0, cmd_wdata = '0, cmd_old = '0;
    logic mem_req_valid, mem_req_we;
    logic mem_req_ready;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic [3:0] mem_req_be;
    logic [9:0] mem_req_asid;
    logic mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic res_valid;
    logic [VW-1:0] res_data;
    logic [1:0] res_thread;

    vlsu_lane_seq #(.LANES(LANES), .THREADS(THREADS)) u0 (
        .clk(clk), .rst(rst), .asid_table(asid_table),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_size(cmd_size), .cmd_signed(cmd_signed), .cmd_thread(cmd_thread),
        .cmd_mask(cmd_mask), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_old(cmd_old), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_be(mem_req_be), .mem_req_asid(mem_req_asid),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_data(res_data), .res_thread(res_thread)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] memfn(input logic [31:0] a);
        return ({a[31:2], 2'b00} * 32'h9E3779B1) ^ 32'h5A5A_3C3C;
    endfunction

    function automatic logic [9:0] asid_of(input int t);
        return 10'(10'h0C5 + t * 97);
    endfunction

    // Memory model with varying ready and latency; logs every accepted request.
    logic [31:0] la [16];
    logic [31:0] lw [16];
    logic [3:0]  lbe [16];
    logic        lwe [16];
    logic [9:0]  lasid [16];
    int log_n = 0;
    int ovl_err = 0;
    int cnt = 0;
    int rdy_ctr = 0;
    int nreq = 0;
    logic [31:0] last_a;
    bit hold_q = 1'b0;
    logic [31:0] hold_a;

    always @(negedge clk) begin
        if (rst) begin
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = '0;
            cnt = 0;
            hold_q = 1'b0;
        end else begin
            mem_rsp_valid = 1'b0;
            if (hold_q) // R12: stalled request must persist unchanged
                chk(mem_req_valid && mem_req_addr == hold_a, "R12 hold", mem_req_addr, hold_a);
            hold_q = 1'b0;
            if (cnt > 0 && mem_req_valid) ovl_err++;
            rdy_ctr++;
            mem_req_ready = (rdy_ctr % 3) != 0;
            if (mem_req_valid && mem_req_ready) begin
                if (log_n < 16) begin
                    la[log_n] = mem_req_addr; lw[log_n] = mem_req_wdata;
                    lbe[log_n] = mem_req_be; lwe[log_n] = mem_req_we;
                    lasid[log_n] = mem_req_asid;
                end
                log_n++;
                last_a = mem_req_addr;
                cnt = 1 + (nreq % 3);
                nreq++;
            end else if (mem_req_valid) begin
                hold_q = 1'b1;
                hold_a = mem_req_addr;
            end else if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = memfn(last_a);
                end
            end
        end
    end

    logic [VW-1:0] r_data;
    logic [1:0] r_tid;
    int r_wait;

    task automatic run_op(input logic [1:0] op, input logic [1:0] sz, input bit sgn,
                          input logic [1:0] tid, input logic [LANES-1:0] mask,
                          input logic [VW-1:0] addr, input logic [VW-1:0] wd,
                          input logic [VW-1:0] old, input bit expect_busy);
        log_n = 0;
        ovl_err = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_size = sz; cmd_signed = sgn;
        cmd_thread = tid; cmd_mask = mask; cmd_addr = addr; cmd_wdata = wd;
        cmd_old = old;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (expect_busy) chk(cmd_ready == 1'b0, "R11 busy", 32'(cmd_ready), 0);
        r_wait = 0;
        while (!res_valid && r_wait < 500) begin
            @(negedge clk);
            r_wait++;
        end
        r_data = res_data;
        r_tid = res_thread;
        chk(r_tid == tid, "R11 thread", 32'(r_tid), 32'(tid));
        chk(ovl_err == 0, "R6 overlap", ovl_err, 0);
        @(negedge clk);
        chk(!res_valid && cmd_ready, "R11 pulse", 32'({res_valid, cmd_ready}), 1);
    endtask

    function automatic logic [VW-1:0] mk_vec(input logic [31:0] base, input logic [31:0] step);
        logic [VW-1:0] v;
        for (int i = 0; i < LANES; i++) v[i*32 +: 32] = base + 32'(i) * step;
        return v;
    endfunction

    task automatic t_reset;
        chk(cmd_ready == 1'b1, "R1 ready", 32'(cmd_ready), 1);
        chk(mem_req_valid == 1'b0, "R1 req", 32'(mem_req_valid), 0);
        chk(res_valid == 1'b0, "R1 res", 32'(res_valid), 0);
    endtask

    task automatic t_gather(input logic [LANES-1:0] mask, input logic [1:0] sz,
                            input logic [1:0] tid);
        logic [VW-1:0] a, o;
        int k;
        a = mk_vec(32'h2000_0100 + 32'(mask), 32'h40);
        o = mk_vec(32'hDEAD_0000, 32'h11);
        run_op(2'b10, sz, 1'b0, tid, mask, a, '0, o, 1'b1);
        chk(log_n == $countones(mask), "R2 count", log_n, $countones(mask));
        k = 0;
        for (int i = 0; i < LANES; i++) begin
            if (mask[i]) begin
                chk(la[k] == a[i*32 +: 32], "R2 order/addr", la[k], a[i*32 +: 32]);
                chk(lwe[k] == 1'b0, "R2 read", 32'(lwe[k]), 0);
                chk(lbe[k] == 4'hF, "R5 tetra", 32'(lbe[k]), 32'hF);
                chk(lasid[k] == asid_of(tid), "R10 asid", 32'(lasid[k]), 32'(asid_of(tid)));
                chk(r_data[i*32 +: 32] == memfn(a[i*32 +: 32]), "R2 data",
                    r_data[i*32 +: 32], memfn(a[i*32 +: 32]));
                k++;
            end else begin
                chk(r_data[i*32 +: 32] == o[i*32 +: 32], "R3 keep old",
                    r_data[i*32 +: 32], o[i*32 +: 32]);
            end
        end
    endtask

    task automatic t_scatter(input logic [LANES-1:0] mask, input logic [1:0] tid);
        logic [VW-1:0] a, d, o;
        int k;
        a = mk_vec(32'h3000_0040, 32'h104);
        d = mk_vec(32'hC0DE_0001, 32'h0101_0101);
        o = mk_vec(32'h0BAD_0000, 32'h7);
        run_op(2'b11, 2'b00, 1'b0, tid, mask, a, d, o, 1'b1);
        chk(log_n == $countones(mask), "R4 count", log_n, $countones(mask));
        k = 0;
        for (int i = 0; i < LANES; i++) begin
            if (mask[i]) begin
                chk(la[k] == a[i*32 +: 32], "R4 addr", la[k], a[i*32 +: 32]);
                chk(lw[k] == d[i*32 +: 32], "R4 data", lw[k], d[i*32 +: 32]);
                chk(lwe[k] == 1'b1, "R4 write", 32'(lwe[k]), 1);
                chk(lbe[k] == 4'hF, "R5 tetra", 32'(lbe[k]), 32'hF);
                chk(lasid[k] == asid_of(tid), "R10 asid", 32'(lasid[k]), 32'(asid_of(tid)));
                k++;
            end
        end
        chk(r_data == o, "R4 result", r_data[31:0], o[31:0]);
    endtask

    task automatic t_empty;
        logic [VW-1:0] o;
        o = mk_vec(32'h5555_0000, 32'h3);
        run_op(2'b10, 2'b10, 1'b0, 2'd2, '0, mk_vec(32'h100, 4), '0, o, 1'b0);
        chk(log_n == 0, "R7 no request", log_n, 0);
        chk(r_wait == 0, "R7 one cycle", r_wait, 0);
        chk(r_data == o, "R3 keep old", r_data[31:0], o[31:0]);
    endtask

    task automatic t_sload(input logic [1:0] sz, input logic [1:0] off, input bit sgn);
        logic [VW-1:0] a, o;
        logic [31:0] w, e;
        logic [7:0] b;
        logic [15:0] h;
        a = mk_vec(32'h0000_4A10 + 32'(off) + 32'(sz) * 32'h100, 32'h20);
        o = mk_vec(32'h7777_0000, 32'h5);
        run_op(2'b00, sz, sgn, 2'd1, 8'h00, a, '0, o, 1'b1);
        w = memfn(a[31:0]);
        b = 8'(w >> (8 * off));
        h = 16'(w >> (16 * off[1]));
        if (sz == 2'b00) e = sgn ? {{24{b[7]}}, b} : {24'b0, b};
        else if (sz == 2'b01) e = sgn ? {{16{h[15]}}, h} : {16'b0, h};
        else e = w;
        chk(log_n == 1, "R8 single read", log_n, 1);
        chk(la[0] == a[31:0] && lwe[0] == 1'b0, "R8 addr", la[0], a[31:0]);
        chk(r_data[31:0] == e, "R8 extract/extend", r_data[31:0], e);
        chk(r_data[VW-1:32] == o[VW-1:32], "R8 upper lanes", r_data[63:32], o[63:32]);
    endtask

    task automatic t_sstore(input logic [1:0] sz, input logic [1:0] off);
        logic [VW-1:0] a, d;
        logic [31:0] ed;
        logic [3:0] eb;
        a = mk_vec(32'h0000_9000 + 32'(off), 32'h10);
        d = mk_vec(32'h89AB_CDEF, 32'h1);
        run_op(2'b01, sz, 1'b0, 2'd3, 8'hFF, a, d, '0, 1'b1);
        if (sz == 2'b00) begin
            ed = {24'b0, d[7:0]} << (8 * off); eb = 4'b0001 << off;
        end else if (sz == 2'b01) begin
            ed = {16'b0, d[15:0]} << (16 * off[1]); eb = 4'b0011 << (2 * off[1]);
        end else begin
            ed = d[31:0]; eb = 4'hF;
        end
        chk(log_n == 1, "R9 single write", log_n, 1);
        chk(lwe[0] == 1'b1 && la[0] == a[31:0], "R9 addr", la[0], a[31:0]);
        chk(lw[0] == ed, "R9 data", lw[0], ed);
        chk(lbe[0] == eb, "R9 be", 32'(lbe[0]), 32'(eb));
        chk(lasid[0] == asid_of(3), "R10 asid", 32'(lasid[0]), 32'(asid_of(3)));
    endtask

    initial begin
        for (int t = 0; t < THREADS; t++) asid_table[t*10 +: 10] = asid_of(t);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_gather(8'hFF, 2'b10, 2'd1);
        t_gather(8'b1010_0110, 2'b00, 2'd0);
        t_gather(8'b1000_0000, 2'b01, 2'd2);
        t_scatter(8'b1000_0001, 2'd3);
        t_scatter(8'b0101_1010, 2'd0);
        t_empty();
        for (int off = 0; off < 4; off++) begin
            t_sload(2'b00, 2'(off), 1'b1);
            t_sload(2'b00, 2'(off), 1'b0);
        end
        t_sload(2'b01, 2'd0, 1'b1);
        t_sload(2'b01, 2'd2, 1'b1);
        t_sload(2'b01, 2'd2, 1'b0);
        t_sload(2'b10, 2'd0, 1'b1);
        t_sstore(2'b00, 2'd3);
        t_sstore(2'b00, 2'd1);
        t_sstore(2'b01, 2'd2);
        t_sstore(2'b10, 2'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule